// File: doc/BRIEF.md
# I2C Target with Sign-Magnitude Current Channel Registers

This block is a bus target on a two-wire serial bus. It holds one 8-bit output code for each current-output channel. Each code is split into two fields for the analog stage: a direction flag that selects whether the channel sources or sinks current, and a 7-bit magnitude.

A fast system clock samples the clock and data lines. Both lines pass through a two-flop synchronizer and a short glitch filter. The block then detects bus start, repeated start and stop events, and shifts bits in on the rising edges of the bus clock.

The 7-bit target address has two parts. The upper five bits are a fixed parameter. The lower two bits come from strap pins.

- **Writes:** the controller sends the address byte, then a register pointer byte, then any number of data bytes.
- **Reads:** the target returns bytes starting at the current pointer.
- **Pointer:** after every data byte, in either direction, the pointer advances by one.

Top module: `i2c_dac_regs`

## Requirements
- R1: After reset, every channel code is 0x00, so every source flag and every magnitude output reads 0, and the data line is not driven.
- R2: An address byte whose upper seven bits equal {ADDR_HI, addr_pin} is acknowledged. Any other address is not acknowledged. After a mismatch, no later byte is acknowledged and no channel changes until the next start.
- R3: A write transaction carries, in order, the address byte with bit 0 = 0, a pointer byte and data bytes. The target acknowledges each of these bytes. Pointer values 0xF8, 0xF9, 0xFA and 0xFB select channels 0, 1, 2 and 3.
- R4: For each channel, ch_src equals bit 7 of its code (1 = source, 0 = sink), and ch_mag equals bits 6:0 of the code. For example, code 0xAA gives source with magnitude 42.
- R5: The pointer advances by one after every data byte written, wrapping modulo 256. A write to a pointer outside 0xF8..0xFB is acknowledged but changes no channel.
- R6: After an address byte with bit 0 = 1, the target sends bytes starting at the current pointer, MSB first. It changes the data line only while the bus clock is low. A pointer outside the channel range reads 0x00. The pointer advances after each byte sent.
- R7: When the controller answers a read byte with a not-acknowledge, the target releases the line and ignores the bus until the next start.
- R8: A repeated start, with no stop in between, restarts address matching. A write that sets the pointer can therefore be followed directly by a read from that pointer.
- R9: A stop returns the target to idle with the line released. Bytes clocked after a stop, without a new start, are neither acknowledged nor written.
- R10: A pulse on either bus line that lasts fewer than FILT system clocks is ignored. For example, a short low pulse on the bus clock during a data bit adds no extra bit.
- R11: The target only ever pulls the data line low, and only starts pulling it low while the filtered bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| addr_pin | input | 2 | Strap pins giving the two low address bits |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| ch_src | output | NCH | Per-channel direction flag, 1 = source |
| ch_mag | output | NCH*7 | Per-channel magnitude, channel i at bits 7i+6:7i |

## Verification
Some properties are checked on every cycle:
- the data line starts being driven only while the filtered clock is low;
- the line stays released in idle, after a stop and while traffic is being ignored;
- channel outputs change only on the cycle after a filtered clock rise.

Other behaviours need bus scenarios and are shown only by the bench's transactions:
- address matching and the rejection that follows a mismatch;
- pointer auto-increment across the channel range boundary;
- reads through a repeated start, and the end of a read on not-acknowledge;
- rejection of a glitch on the bus clock.

// File: rtl/i2c_dac_regs.sv
module i2c_dac_regs #(
  parameter int         NCH      = 4,
  parameter int         CW       = 8,
  parameter logic [4:0] ADDR_HI  = 5'b01000,
  parameter logic [7:0] REG_BASE = 8'hF8,
  parameter int         FILT     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        addr_pin,
  output logic              sda_oe,
  output logic [NCH-1:0]    ch_src,
  output logic [NCH*(CW-1)-1:0] ch_mag
);
  localparam int MW  = CW - 1;
  localparam int FCW = $clog2(FILT + 1);
  localparam int IW  = (NCH > 1) ? $clog2(NCH) : 1;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_PTR, S_WR, S_RD, S_IGN} st_t;

  logic [1:0] raw, s1, s2, flt, flt_d;
  logic [FCW-1:0] fc [2];

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1[g]  <= 1'b1;
        s2[g]  <= 1'b1;
        flt[g] <= 1'b1;
        fc[g]  <= '0;
      end else begin
        s1[g] <= raw[g];
        s2[g] <= s1[g];
        if (s2[g] != flt[g]) begin
          if (fc[g] == FCW'(FILT - 1)) begin
            flt[g] <= s2[g];
            fc[g]  <= '0;
          end else begin
            fc[g] <= fc[g] + 1'b1;
          end
        end else begin
          fc[g] <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flt_d <= 2'b11;
    else        flt_d <= flt;

  logic scl_f, sda_f, scl_rise, scl_fall, start, stop;
  assign scl_f    = flt[1];
  assign sda_f    = flt[0];
  assign scl_rise = scl_f & ~flt_d[1];
  assign scl_fall = ~scl_f & flt_d[1];
  assign start    = flt_d[1] & scl_f & flt_d[0] & ~sda_f;
  assign stop     = flt_d[1] & scl_f & ~flt_d[0] & sda_f;

  st_t        st;
  logic [3:0] bitcnt;
  logic       in_ack, ack_go, rw, mack;
  logic [6:0] sh, tx;
  logic [7:0] ptr;
  logic [CW-1:0] regs [NCH];

  logic [7:0]    rx, idx;
  logic          in_rng, addr_ok;
  logic [CW-1:0] rd_byte;

  assign rx      = {sh, sda_f};
  assign idx     = ptr - REG_BASE;
  assign in_rng  = idx < 8'(NCH);
  assign rd_byte = in_rng ? regs[idx[IW-1:0]] : '0;
  assign addr_ok = rx[7:1] == {ADDR_HI, addr_pin};

  logic is_idle, is_ign;
  assign is_idle = st == S_IDLE;
  assign is_ign  = st == S_IGN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      bitcnt <= '0;
      in_ack <= 1'b0;
      ack_go <= 1'b0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      sh     <= '0;
      tx     <= '0;
      ptr    <= '0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NCH; i++) regs[i] <= '0;
    end else if (start) begin
      st     <= S_ADDR;
      bitcnt <= '0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop) begin
      st     <= S_IDLE;
      bitcnt <= '0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (st != S_IDLE && st != S_IGN) begin
      if (scl_rise) begin
        if (!in_ack) begin
          sh     <= rx[6:0];
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == 4'd7) begin
            unique case (st)
              S_ADDR: begin ack_go <= addr_ok; rw <= rx[0]; end
              S_PTR:  begin ack_go <= 1'b1; ptr <= rx; end
              S_WR: begin
                ack_go <= 1'b1;
                if (in_rng) regs[idx[IW-1:0]] <= rx;
                ptr <= ptr + 1'b1;
              end
              S_RD:   begin ack_go <= 1'b0; ptr <= ptr + 1'b1; end
              default: ;
            endcase
          end
        end else if (st == S_RD) begin
          mack <= ~sda_f;
        end
      end else if (scl_fall) begin
        if (!in_ack && bitcnt == 4'd8) begin
          in_ack <= 1'b1;
          sda_oe <= (st != S_RD) && ack_go;
        end else if (in_ack) begin
          in_ack <= 1'b0;
          bitcnt <= '0;
          sda_oe <= 1'b0;
          unique case (st)
            S_ADDR:
              if (!ack_go) st <= S_IGN;
              else if (rw) begin
                st     <= S_RD;
                tx     <= rd_byte[6:0];
                sda_oe <= ~rd_byte[7];
              end else st <= S_PTR;
            S_PTR: st <= S_WR;
            S_RD:
              if (mack) begin
                tx     <= rd_byte[6:0];
                sda_oe <= ~rd_byte[7];
              end else st <= S_IGN;
            default: ;
          endcase
        end else if (st == S_RD) begin
          sda_oe <= ~tx[6];
          tx     <= {tx[5:0], 1'b0};
        end
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_src[c]           = regs[c][CW-1];
    assign ch_mag[c*MW +: MW]  = regs[c][MW-1:0];
  end
endmodule

// File: rtl/i2c_dac_regs_chk.sv
module i2c_dac_regs_chk #(
  parameter int NCH = 4,
  parameter int MW  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_f,
  input logic              scl_rise,
  input logic              stop,
  input logic              sda_oe,
  input logic              is_idle,
  input logic              is_ign,
  input logic [NCH-1:0]    ch_src,
  input logic [NCH*MW-1:0] ch_mag
);
  p_oe_rise_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);

  p_ch_change_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({ch_src, ch_mag}) |-> $past(scl_rise));

  p_ignore_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_ign |-> !sda_oe);

  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop) |-> !sda_oe);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_idle |-> !sda_oe);
endmodule

bind i2c_dac_regs i2c_dac_regs_chk #(.NCH(NCH), .MW(CW - 1)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_f    (scl_f),
  .scl_rise (scl_rise),
  .stop     (stop),
  .sda_oe   (sda_oe),
  .is_idle  (is_idle),
  .is_ign   (is_ign),
  .ch_src   (ch_src),
  .ch_mag   (ch_mag)
);

// File: tb/i2c_dac_regs_tb.sv
`timescale 1ns/1ps
module i2c_dac_regs_tb;
  localparam int H = 10;
  localparam logic [6:0] DEV = {5'b01000, 2'b10};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [3:0]  ch_src;
  logic [27:0] ch_mag;
  wire sda_bus = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_dac_regs u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_pin(2'b10), .sda_oe(sda_oe), .ch_src(ch_src), .ch_mag(ch_mag)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_reg [4];
  logic [7:0] m_ptr;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit in_rng(input logic [7:0] p);
    return p >= 8'hF8 && p <= 8'hFB;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] p);
    return in_rng(p) ? m_reg[p - 8'hF8] : 8'h00;
  endfunction

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(H);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic wbit(input bit b, input bit glitch);
    sda_m = b; wt(H); scl_m = 1'b1;
    if (glitch) begin wt(4); scl_m = 1'b0; wt(2); scl_m = 1'b1; end
    wt(H); scl_m = 1'b0; wt(2);
  endtask

  task automatic rbit(output bit b);
    sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H/2); b = sda_bus;
    wt(H/2); scl_m = 1'b0; wt(2);
  endtask

  task automatic wbyte(input logic [7:0] d, input int gpos, output bit ack);
    bit a;
    for (int i = 7; i >= 0; i--) wbit(d[i], i == gpos);
    rbit(a);
    ack = ~a;
  endtask

  task automatic rbyte(input bit give_ack, output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    wbit(~give_ack, 1'b0);
  endtask

  task automatic check_outs(input string req);
    for (int i = 0; i < 4; i++) begin
      chk(ch_src[i] == m_reg[i][7], req, int'(ch_src[i]), int'(m_reg[i][7]));
      chk(ch_mag[i*7 +: 7] == m_reg[i][6:0], req, int'(ch_mag[i*7 +: 7]), int'(m_reg[i][6:0]));
    end
  endtask

  task automatic wr_txn(input logic [7:0] p, input int n, input int gpos, input string req);
    bit ack;
    logic [7:0] d;
    bus_start;
    wbyte({DEV, 1'b0}, -1, ack); chk(ack, "R2 addr ack", int'(ack), 1);
    wbyte(p, -1, ack);           chk(ack, "R3 ptr ack", int'(ack), 1);
    m_ptr = p;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      wbyte(d, gpos, ack);
      chk(ack, req, int'(ack), 1);
      if (in_rng(m_ptr)) m_reg[m_ptr - 8'hF8] = d;
      m_ptr++;
    end
    bus_stop;
  endtask

  task automatic rd_txn(input logic [7:0] p, input int n, input string req);
    bit ack;
    logic [7:0] d;
    bus_start;
    wbyte({DEV, 1'b0}, -1, ack); chk(ack, "R8 addr ack", int'(ack), 1);
    wbyte(p, -1, ack);           chk(ack, "R8 ptr ack", int'(ack), 1);
    m_ptr = p;
    bus_start;
    wbyte({DEV, 1'b1}, -1, ack); chk(ack, "R8 read addr ack after Sr", int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      rbyte(k != n - 1, d);
      chk(d == exp_rd(m_ptr), req, int'(d), int'(exp_rd(m_ptr)));
      m_ptr++;
    end
    bus_stop;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_chk, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] d;
    process::self().srandom(32'd1234);
    for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;
    m_ptr = 8'h00;
    wt(5); rst_n = 1'b1; wt(5);

    // R1 reset state
    chk(ch_src == 4'h0, "R1 src", int'(ch_src), 0);
    chk(ch_mag == 28'h0, "R1 mag", int'(ch_mag), 0);
    chk(sda_oe == 1'b0, "R1 line released", int'(sda_oe), 0);

    // R4 directed decode of 0xAA on channel 0
    bus_start;
    wbyte({DEV, 1'b0}, -1, ack); chk(ack, "R2 addr ack", int'(ack), 1);
    wbyte(8'hF8, -1, ack);       chk(ack, "R3 ptr ack", int'(ack), 1);
    wbyte(8'hAA, -1, ack);       chk(ack, "R3 data ack", int'(ack), 1);
    bus_stop;
    m_reg[0] = 8'hAA;
    chk(ch_src[0] == 1'b1, "R4 src 0xAA", int'(ch_src[0]), 1);
    chk(ch_mag[6:0] == 7'd42, "R4 mag 0xAA", int'(ch_mag[6:0]), 42);
    chk(sda_oe == 1'b0, "R11 released after stop", int'(sda_oe), 0);

    // R5 auto-increment across the range end; out-of-range writes ignored
    wr_txn(8'hF9, 3, -1, "R5 data ack");
    check_outs("R5 after F9..FB");
    wr_txn(8'hFA, 4, -1, "R5 ack out of range");
    check_outs("R5 after FA..FD");
    wr_txn(8'hF6, 3, -1, "R5 ack below range");
    check_outs("R5 after F6..F8");

    // R2 address mismatch then ignored traffic
    bus_start;
    wbyte({5'b01000, 2'b01, 1'b0}, -1, ack); chk(!ack, "R2 wrong addr nack", int'(ack), 0);
    wbyte(8'hF8, -1, ack); chk(!ack, "R2 ignored ptr", int'(ack), 0);
    wbyte(8'h00, -1, ack); chk(!ack, "R2 ignored data", int'(ack), 0);
    bus_stop;
    check_outs("R2 no change");

    // R9 bytes after stop without start ignored
    wbyte(8'hF9, -1, ack); chk(!ack, "R9 no ack after stop", int'(ack), 0);
    wbyte(8'h00, -1, ack); chk(!ack, "R9 no ack after stop", int'(ack), 0);
    bus_stop;
    check_outs("R9 no change");

    // R6 R8 reads across the range, including out of range
    rd_txn(8'hF8, 4, "R6 read F8..FB");
    rd_txn(8'hF6, 3, "R6 read F6..F8");
    rd_txn(8'hFB, 2, "R6 read FB..FC");

    // R7 after master NACK the target ignores until START
    bus_start;
    wbyte({DEV, 1'b1}, -1, ack); chk(ack, "R7 read addr ack", int'(ack), 1);
    rbyte(1'b0, d);
    chk(d == exp_rd(m_ptr), "R7 first read", int'(d), int'(exp_rd(m_ptr)));
    m_ptr++;
    wbyte(8'h00, -1, ack); chk(!ack, "R7 ignored after nack", int'(ack), 0);
    chk(sda_oe == 1'b0, "R7 line released", int'(sda_oe), 0);
    bus_stop;

    // R10 glitch on SCL during a data bit
    wr_txn(8'hF9, 1, 3, "R10 ack with glitch");
    check_outs("R10 glitch filtered");
    wr_txn(8'hFB, 1, 6, "R10 ack with glitch");
    check_outs("R10 glitch filtered");

    // constrained random mix
    for (int t = 0; t < 36; t++) begin
      int kind;
      logic [7:0] p;
      kind = $urandom_range(0, 9);
      p = 8'($urandom_range(8'hF5, 8'hFD));
      if (kind < 5) begin
        wr_txn(p, $urandom_range(1, 3), -1, "R3 R5 random write ack");
        check_outs("R4 random write outputs");
      end else if (kind < 9) begin
        rd_txn(p, $urandom_range(1, 3), "R6 random read");
      end else begin
        bus_start;
        wbyte({DEV ^ 7'($urandom_range(1, 3)), 1'b0}, -1, ack);
        chk(!ack, "R2 random wrong addr", int'(ack), 0);
        wbyte(p, -1, ack); chk(!ack, "R2 random ignored", int'(ack), 0);
        bus_stop;
        check_outs("R2 random no change");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule